// File: doc/BRIEF.md
# Shared-Bus Register Transfer Adder

This block is a small processor datapath in which every transfer between storage elements goes over one internal bus. It holds four general registers, an operand register Y and a result register Z. The ALU between Y and Z is purely combinational and stores nothing. Its A input always comes from Y and its B input comes straight from the bus.

A register-to-register add is requested with a single start pulse that carries two source indices and a destination index. A sequencer then runs three steps. In the first step, the first source register is placed on the bus and copied into Y. In the second step, the second source register is placed on the bus and the sum of Y and the bus is captured in Z. In the third step, Z drives the bus and the destination register takes the value. A done pulse follows in the next cycle.

While the sequencer is idle, a load gate can place an external value on the bus and write it into a chosen general register. A combinational read port makes the register contents visible. The bus itself is also brought out so that each step can be observed.

Top module: `onebus_adder`

## Requirements
- R1: After reset, all four general registers read 0, `busy` and `done` are 0, and `bus` is 0.
- R2: While idle, `wr_en` writes `wr_data` into the register selected by `wr_idx` at the clock edge, and the other three registers keep their values.
- R3: Let the start pulse be sampled at clock edge E0. Then `bus` shows the first source in the cycle after E0, the second source in the cycle after that, and the sum in the third cycle. The destination register is written at edge E0+3. `done` is high for exactly the one cycle after E0+3.
- R4: The sum is (first source + second source) modulo 256, and the carry out is discarded.
- R5: Both source indices may name the same register, and the destination may equal either source. The result is always computed from the values the registers held when the operation started.
- R6: While `busy` is high, `start` and `wr_en` are ignored. No register other than the destination changes, and no second operation is launched.
- R7: An add writes only its destination register. The other general registers keep their values.
- R8: At most one source drives the bus in any cycle. `bus` reads 0 whenever no source drives it, including the done cycle and idle cycles without `wr_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts an add when idle |
| src_a | input | 2 | First source register index (staged in Y) |
| src_b | input | 2 | Second source register index (ALU B input) |
| dst | input | 2 | Destination register index |
| wr_en | input | 1 | External load request, honoured only when idle |
| wr_idx | input | 2 | Register written by the external load |
| wr_data | input | 8 | Value driven onto the bus by the external load |
| rd_idx | input | 2 | Register selected for the read port |
| rd_data | output | 8 | Current value of the selected register |
| bus | output | 8 | Current value of the shared bus |
| busy | output | 1 | High from the first step through the done cycle |
| done | output | 1 | One-cycle pulse after the write-back step |

## Verification
The add is swept over all 64 combinations of first source, second source and destination. For each combination the register file is reloaded with fresh values, so a wrong index in any step shows up as a wrong bus value or a wrong result. The value sets include pairs whose sum exceeds 255, which separates true modulo arithmetic from a stray carry. The combinations where sources and destination coincide separate staging through Y from rereading a register that was already overwritten. A separate run applies `start` and `wr_en` while an operation is in flight, to show that neither disturbs the result or any other register.

// File: rtl/onebus_adder.sv
module onebus_adder #(
  parameter int W    = 8,
  parameter int NREG = 4,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] src_a,
  input  logic [IW-1:0] src_b,
  input  logic [IW-1:0] dst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data,
  output logic [W-1:0]  bus,
  output logic          busy,
  output logic          done
);

  typedef enum logic [2:0] {IDLE, STEP1, STEP2, STEP3, FIN} step_t;

  step_t           state;
  logic [IW-1:0]   a_q, b_q, d_q;
  logic [W-1:0]    gpr [NREG];
  logic [W-1:0]    y_q, z_q;
  logic [W-1:0]    alu;
  logic [NREG-1:0] reg_out, reg_in;
  logic            z_out, ext_out;

  assign ext_out = (state == IDLE) && wr_en;
  assign z_out   = (state == STEP3);

  always_comb begin
    reg_out = '0;
    reg_in  = '0;
    if (state == STEP1) reg_out[a_q] = 1'b1;
    if (state == STEP2) reg_out[b_q] = 1'b1;
    if (state == STEP3) reg_in[d_q]  = 1'b1;
    if (ext_out)        reg_in[wr_idx] = 1'b1;
  end

  always_comb begin
    bus = (z_out ? z_q : '0) | (ext_out ? wr_data : '0);
    for (int i = 0; i < NREG; i++)
      bus = bus | (reg_out[i] ? gpr[i] : '0);
  end

  assign alu     = y_q + bus;
  assign rd_data = gpr[rd_idx];
  assign busy    = (state != IDLE);
  assign done    = (state == FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE;
      a_q   <= '0;
      b_q   <= '0;
      d_q   <= '0;
      y_q   <= '0;
      z_q   <= '0;
    end else begin
      case (state)
        IDLE:  if (start) begin
                 state <= STEP1;
                 a_q   <= src_a;
                 b_q   <= src_b;
                 d_q   <= dst;
               end
        STEP1: begin y_q <= bus; state <= STEP2; end
        STEP2: begin z_q <= alu; state <= STEP3; end
        STEP3: state <= FIN;
        default: state <= IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_gpr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         gpr[g] <= '0;
      else if (reg_in[g]) gpr[g] <= bus;
    end
  end

  assert_one_driver_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_out, z_out, ext_out}));

  assert_idle_bus_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_out == '0 && !z_out && !ext_out) |-> (bus == '0));

  assert_y_takes_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == STEP1) |=> (y_q == $past(bus)));

  assert_done_after_step3_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == STEP3) |=> done);

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state != IDLE) |=> (state != STEP1));

endmodule

// File: tb/onebus_adder_bench.sv
module onebus_adder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] src_a = '0, src_b = '0, dst = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_idx = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_idx = '0;
  logic [7:0] rd_data, bus;
  logic       busy, done;

  int checks = 0;
  int fails  = 0;
  int m [4];

  always #2 clk = ~clk;

  onebus_adder u_onebus_adder (
    .clk(clk), .rst_n(rst_n), .start(start), .src_a(src_a), .src_b(src_b),
    .dst(dst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .bus(bus), .busy(busy), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < 4; i++) begin
      rd_idx = i[1:0];
      #0.1;
      check(req, rd_data, m[i]);
    end
  endtask

  task automatic load(input int idx, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx[1:0]; wr_data = val[7:0];
    @(negedge clk);
    wr_en = 1'b0;
    m[idx] = val & 255;
  endtask

  task automatic run_add(input int a, input int b, input int d, input bit disturb);
    int sum;
    sum = (m[a] + m[b]) % 256;
    @(negedge clk);
    start = 1'b1; src_a = a[1:0]; src_b = b[1:0]; dst = d[1:0];
    @(negedge clk);
    start = 1'b0;
    check("R3 step1 bus", bus, m[a]);
    check("R3 busy", busy, 1);
    @(negedge clk);
    check("R3 step2 bus", bus, m[b]);
    if (disturb) begin
      start = 1'b1; src_a = ~a[1:0]; src_b = ~b[1:0]; dst = ~d[1:0];
      wr_en = 1'b1; wr_idx = ~d[1:0]; wr_data = 8'h5a;
    end
    @(negedge clk);
    start = 1'b0; wr_en = 1'b0;
    check("R4 step3 sum", bus, sum);
    check("R3 done low", done, 0);
    @(negedge clk);
    check("R3 done pulse", done, 1);
    check("R8 bus idle in done", bus, 0);
    m[d] = sum;
    @(negedge clk);
    check("R3 done one cycle", done, 0);
    check("R6 busy cleared", busy, 0);
    check_regs("R7 registers after add");
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m[i] = 0;
    #5;
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 bus", bus, 0);
    check_regs("R1 reset registers");
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 4; i++) begin
      load(i, 17 * i + 3);
      check_regs("R2 load");
    end
    check("R8 idle bus", bus, 0);

    for (int k = 0; k < 64; k++) begin
      for (int i = 0; i < 4; i++) load(i, (k * 37 + i * 91 + 120) % 256);
      run_add(k % 4, (k / 4) % 4, k / 16, 1'b0);
    end

    load(0, 255); load(1, 1);
    run_add(0, 1, 2, 1'b0);
    check("R4 wrap to zero", m[2], 0);
    load(0, 200);
    run_add(0, 0, 0, 1'b0);
    check("R5 double in place", m[0], 144);

    load(0, 10); load(1, 20); load(2, 30); load(3, 40);
    run_add(0, 1, 2, 1'b1);
    check_regs("R6 disturb ignored");
    repeat (3) begin
      @(negedge clk);
      check("R6 no second op", busy, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule